// File: doc/BRIEF.md
# Receive Octet Packer and Buffer Writer

This block sits behind the deframer of one serial receive channel. It gathers the incoming data bits into octets and writes each finished octet to external memory through a plain write port. Successive octets go to consecutive byte addresses inside a buffer that the surrounding logic hands over as a descriptor, made of a start address and a length in bytes.

A buffer is closed when the frame ends or when its last byte has been written, whichever happens first. The block then reports a done event with the number of bytes written, whether the frame end closed it, and how many bits the trailing partial octet held. The next octet goes to the start of the next descriptor. Descriptors are taken one at a time, when the block holds no buffer or is closing the current one. If octets arrive while no buffer is held, they are discarded and an overrun flag is raised.

Top module: `rx_octet_packer`

## Requirements
- R1: Bits are packed least significant first: the first accepted bit of an octet lands in wr_data bit 0 and the eighth lands in bit 7.
- R2: The first octet of a buffer is written at the descriptor's start address, and each further octet in that buffer is written at the previous address plus one, in arrival order.
- R3: When a buffer's final byte (count equal to its length) is written, the buffer closes with done_vld, done_cnt equal to the length and done_eof low, and the next octet goes to the start address of the next descriptor.
- R4: An end-of-frame pulse closes the current buffer with done_vld, done_eof high and done_cnt equal to the bytes written into it, including any byte written in that cycle.
- R5: At end of frame with 1 to 7 pending bits, those bits are written as one byte with the unfilled high bits zero, and done_resid reports the pending bit count; done_resid is 0 when the last byte was whole.
- R6: An octet that completes while no buffer is held is discarded with no write, and ovr goes high; ovr returns low when a descriptor is accepted in a cycle with no discard.
- R7: A descriptor whose length is zero is never accepted: desc_take stays low for it.
- R8: An end-of-frame pulse with no pending bits while the held buffer is still empty causes no done event and leaves the buffer in use.
- R9: After reset no write or done event is issued, ovr is low and no buffer is held. Writes and done events appear one cycle after the input cycle that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | bit_din carries a received bit this cycle |
| bit_din | input | 1 | Received data bit |
| eof | input | 1 | End of frame; a bit valid in the same cycle is the frame's last |
| desc_vld | input | 1 | A descriptor is offered |
| desc_addr | input | AW | Start byte address of the offered buffer |
| desc_len | input | LW | Length of the offered buffer in bytes |
| desc_take | output | 1 | The offered descriptor is accepted at this edge |
| wr_en | output | 1 | Memory byte write strobe |
| wr_addr | output | AW | Byte address of the write |
| wr_data | output | 8 | Byte written |
| done_vld | output | 1 | A buffer has been closed |
| done_cnt | output | LW | Bytes written into the closed buffer |
| done_eof | output | 1 | The buffer was closed by end of frame |
| done_resid | output | 3 | Bits in the trailing partial byte, 0 if whole |
| ovr | output | 1 | Octets were discarded for lack of a buffer |

## Verification
The bench builds the block with a 12-bit address and the default 16-bit length, and uses buffers of four and eight bytes. Such short buffers make a close on fill followed by a hand-over to a queued descriptor occur within a few octets. They also leave room in one run for a partial trailing octet, an empty frame end, a discard before any buffer exists and a rejected zero-length descriptor.

// File: rtl/rx_octet_packer.sv
module rx_octet_packer #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_vld,
  input  logic          bit_din,
  input  logic          eof,
  input  logic          desc_vld,
  input  logic [AW-1:0] desc_addr,
  input  logic [LW-1:0] desc_len,
  output logic          desc_take,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          done_vld,
  output logic [LW-1:0] done_cnt,
  output logic          done_eof,
  output logic [2:0]    done_resid,
  output logic          ovr
);

  logic          have_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] rem_q, cnt_q;
  logic [7:0]    sr_q;
  logic [2:0]    nb_q;

  logic [3:0] nbits;
  logic [7:0] sr_n;
  logic       full, part, emit, wr, close, drop;

  assign nbits = {1'b0, nb_q} + {3'b0, bit_vld};
  assign sr_n  = bit_vld ? (sr_q | (8'(bit_din) << nb_q)) : sr_q;
  assign full  = nbits[3];
  assign part  = eof && !full && (nbits != 4'd0);
  assign emit  = full || part;
  assign wr    = have_q && emit;
  assign drop  = !have_q && emit;
  assign close = have_q && ((wr && rem_q == LW'(1)) || (eof && (wr || cnt_q != '0)));
  assign desc_take = desc_vld && (desc_len != '0) && (!have_q || close);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q     <= 1'b0;
      addr_q     <= '0;
      rem_q      <= '0;
      cnt_q      <= '0;
      sr_q       <= '0;
      nb_q       <= '0;
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      done_vld   <= 1'b0;
      done_cnt   <= '0;
      done_eof   <= 1'b0;
      done_resid <= '0;
      ovr        <= 1'b0;
    end else begin
      wr_en      <= wr;
      wr_addr    <= addr_q;
      wr_data    <= sr_n;
      done_vld   <= close;
      done_cnt   <= cnt_q + LW'(wr);
      done_eof   <= eof;
      done_resid <= part ? nbits[2:0] : 3'd0;

      if (drop)           ovr <= 1'b1;
      else if (desc_take) ovr <= 1'b0;

      if (emit || eof) begin
        sr_q <= '0;
        nb_q <= '0;
      end else begin
        sr_q <= sr_n;
        nb_q <= nbits[2:0];
      end

      if (desc_take) begin
        have_q <= 1'b1;
        addr_q <= desc_addr;
        rem_q  <= desc_len;
        cnt_q  <= '0;
      end else if (close) begin
        have_q <= 1'b0;
      end else if (wr) begin
        addr_q <= addr_q + AW'(1);
        rem_q  <= rem_q - LW'(1);
        cnt_q  <= cnt_q + LW'(1);
      end
    end
  end

endmodule

module rx_octet_packer_chk #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [LW-1:0] desc_len,
  input logic          desc_take,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [7:0]    wr_data,
  input logic          done_vld,
  input logic [LW-1:0] done_cnt,
  input logic          done_eof,
  input logic [2:0]    done_resid,
  input logic          ovr
);

  p_take_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    desc_take |-> desc_len != '0);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && $past(wr_en) && !$past(done_vld) |-> wr_addr == $past(wr_addr) + AW'(1));

  p_done_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld |-> done_cnt != '0);

  p_fill_whole_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld && !done_eof |-> done_resid == 3'd0);

  p_partial_zero_hi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld && done_resid != 3'd0 |-> wr_en && (wr_data >> done_resid) == 8'd0);

  p_drop_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> !wr_en);

endmodule

bind rx_octet_packer rx_octet_packer_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .desc_len(desc_len), .desc_take(desc_take),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done_vld(done_vld),
  .done_cnt(done_cnt), .done_eof(done_eof), .done_resid(done_resid), .ovr(ovr)
);

// File: tb/rx_octet_packer_test.sv
module rx_octet_packer_test;
  localparam int AW = 12;
  localparam int LW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bit_vld = 1'b0, bit_din = 1'b0, eof = 1'b0;
  logic          desc_vld;
  logic [AW-1:0] desc_addr;
  logic [LW-1:0] desc_len;
  logic          desc_take, wr_en, done_vld, done_eof, ovr;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic [LW-1:0] done_cnt;
  logic [2:0]    done_resid;

  always #4 clk = ~clk;

  rx_octet_packer #(.AW(AW), .LW(LW)) uut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_din(bit_din), .eof(eof),
    .desc_vld(desc_vld), .desc_addr(desc_addr), .desc_len(desc_len),
    .desc_take(desc_take), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done_vld(done_vld), .done_cnt(done_cnt), .done_eof(done_eof),
    .done_resid(done_resid), .ovr(ovr)
  );

  logic [AW-1:0] dq_addr [8];
  logic [LW-1:0] dq_len  [8];
  int dq_head = 0, dq_tail = 0, ntake = 0;
  assign desc_vld  = dq_head != dq_tail;
  assign desc_addr = dq_addr[dq_head % 8];
  assign desc_len  = dq_len[dq_head % 8];
  always @(posedge clk) if (desc_vld && desc_take) begin
    dq_head <= dq_head + 1;
    ntake   <= ntake + 1;
  end

  logic [AW-1:0] la [32];
  logic [7:0]    ld [32];
  logic [LW-1:0] dc [8];
  logic          de [8];
  logic [2:0]    dr [8];
  int nwr = 0, ndone = 0;
  always @(negedge clk) begin
    if (wr_en && nwr < 32) begin la[nwr] = wr_addr; ld[nwr] = wr_data; nwr++; end
    if (done_vld && ndone < 8) begin
      dc[ndone] = done_cnt; de[ndone] = done_eof; dr[ndone] = done_resid; ndone++;
    end
  end

  int checks = 0, fails = 0;
  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(int a, int l);
    dq_addr[dq_tail % 8] = AW'(a);
    dq_len[dq_tail % 8]  = LW'(l);
    dq_tail++;
  endtask

  task automatic send_bit(bit b, bit e);
    bit_vld = 1'b1; bit_din = b; eof = e;
    @(negedge clk);
    bit_vld = 1'b0; eof = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] v, bit e);
    for (int j = 0; j < 8; j++) send_bit(v[j], e && j == 7);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [8:0] VEC [6] = '{
    {1'b0, 8'hA5}, {1'b0, 8'h3C}, {1'b0, 8'h01},
    {1'b0, 8'h80}, {1'b0, 8'hFF}, {1'b1, 8'h5A}
  };
  localparam logic [AW-1:0] EXP_A [8] = '{12'h100, 12'h101, 12'h102, 12'h103,
                                         12'h200, 12'h201, 12'h400, 12'h500};
  localparam logic [7:0] EXP_D [8] = '{8'hA5, 8'h3C, 8'h01, 8'h80,
                                      8'hFF, 8'h5A, 8'h05, 8'h77};

  bit timed_out = 1'b0;

  initial begin
    fork
      begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        chk(!wr_en && !done_vld, "R9 reset no events", {wr_en, done_vld}, 0);
        chk(!ovr, "R9 reset ovr", ovr, 0);

        send_byte(8'hC3, 1'b0);
        idle(2);
        chk(ovr, "R6 ovr on discard", ovr, 1);
        chk(nwr == 0, "R6 no write without buffer", nwr, 0);

        push(12'h100, 4);
        idle(2);
        chk(!ovr, "R6 ovr cleared on accept", ovr, 0);
        push(12'h200, 8);

        for (int i = 0; i < 6; i++) send_byte(VEC[i][7:0], VEC[i][8]);
        idle(3);

        push(12'h400, 8);
        idle(2);
        send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
        eof = 1'b1; @(negedge clk); eof = 1'b0;
        idle(3);

        push(12'h500, 8);
        idle(2);
        eof = 1'b1; @(negedge clk); eof = 1'b0;
        idle(3);
        chk(ndone == 3, "R8 empty eof no done", ndone, 3);
        send_byte(8'h77, 1'b1);
        idle(3);

        chk(nwr == 8, "R2 write count", nwr, 8);
        for (int k = 0; k < 8; k++) begin
          chk(la[k] == EXP_A[k], "R2 R3 write address", la[k], EXP_A[k]);
          chk(ld[k] == EXP_D[k], "R1 R5 write data", ld[k], EXP_D[k]);
        end
        chk(ndone == 4, "R3 R4 done count", ndone, 4);
        chk(dc[0] == 4 && !de[0] && dr[0] == 0, "R3 fill close", {dc[0], de[0]}, {16'd4, 1'b0});
        chk(dc[1] == 2 && de[1] && dr[1] == 0, "R4 eof close", {dc[1], de[1]}, {16'd2, 1'b1});
        chk(dc[2] == 1 && de[2] && dr[2] == 3, "R5 residue", {dc[2], dr[2]}, {16'd1, 3'd3});
        chk(dc[3] == 1 && de[3] && dr[3] == 0, "R8 buffer kept", {dc[3], de[3]}, {16'd1, 1'b1});

        push(12'h600, 0);
        idle(4);
        chk(ntake == 4, "R7 zero length not taken", ntake, 4);
        send_byte(8'h11, 1'b0);
        idle(2);
        chk(nwr == 8 && ovr, "R7 R6 still no buffer", {nwr, ovr}, {8, 1});
      end
      begin
        repeat (5000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    if (timed_out) chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule